// File: doc/BRIEF.md
# Two-Thread Shared Micro-Op Queue

This block buffers micro-ops coming from an upstream stage that works for two logical threads and hands them, one per cycle, to a downstream stage. Each thread has its own enqueue port with a valid/ready handshake. Every stored entry carries a one-bit thread tag. Micro-ops of one thread leave in the order they arrived. The two threads are not ordered against each other.

How entries are shared is fixed when the block is elaborated. There are three policies. In the split policy each thread may hold at most half of the entries. In the capped policy each thread may hold up to a parameter limit, which is smaller than the depth. In the open policy there is no per-thread limit. Admission is decided for each thread separately, so a thread that has reached its limit stalls alone and the other thread keeps enqueuing.

On the drain side, a round-robin arbiter picks between the threads that have something to send. A thread that the downstream stage holds back with its stall bit is skipped. A per-thread flush drops every entry of that thread in one cycle. The per-thread occupancy counts are brought out as outputs.

Top module: `uopq_dual_thread`

## Requirements
- R1: Each micro-op leaves with its payload unchanged and with `out_thread_o` equal to the thread it entered on (0 = `t0_*` port, 1 = `t1_*` port). Micro-ops of one thread leave in the order they were accepted.
- R2: With `MODE` = SHARE_PART, a thread holding DEPTH/2 entries sees its ready low, and its occupancy never exceeds DEPTH/2.
- R3: With `MODE` = SHARE_CAP, a thread's occupancy never exceeds `CAP`, and its ready is low while it holds `CAP` entries.
- R4: With `MODE` = SHARE_FULL, one thread may take all DEPTH entries. While the queue is full, both readies are low.
- R5: A thread that is at its limit does not block the other thread. In that same cycle the other thread's ready stays high if the other thread is under its own limit and a slot is free.
- R6: At most one micro-op leaves per cycle. A thread whose `stall_i` bit is set (bit index = thread) never has a micro-op emitted.
- R7: When both threads are eligible to drain, grants alternate between them. After reset, thread 0 is served first.
- R8: Raising `flush_i[t]` empties thread t at the next edge, so its occupancy becomes 0. In the flush cycle thread t's ready is low and nothing of thread t is emitted. The other thread's entries and their order are unaffected.
- R9: When both threads are valid and each is under its limit, but only one slot is free, exactly one of them is admitted. Thread 0 wins the first such conflict, and the winner alternates on every later conflict.
- R10: After reset both occupancies are 0 and `out_valid_o` is 0. At all times `occ0_o + occ1_o` does not exceed DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| t0_valid_i | input | 1 | Thread 0 offers a micro-op |
| t0_data_i | input | PAYLOAD_W | Thread 0 payload |
| t0_ready_o | output | 1 | Thread 0 may enqueue this cycle |
| t1_valid_i | input | 1 | Thread 1 offers a micro-op |
| t1_data_i | input | PAYLOAD_W | Thread 1 payload |
| t1_ready_o | output | 1 | Thread 1 may enqueue this cycle |
| stall_i | input | 2 | Per-thread downstream hold, bit t for thread t |
| flush_i | input | 2 | Per-thread flush, bit t for thread t |
| out_valid_o | output | 1 | A micro-op leaves this cycle |
| out_thread_o | output | 1 | Thread tag of the leaving micro-op |
| out_data_o | output | PAYLOAD_W | Payload of the leaving micro-op |
| occ0_o | output | clog2(DEPTH+1) | Entries held by thread 0 |
| occ1_o | output | clog2(DEPTH+1) | Entries held by thread 1 |

## Verification
Ready is combinational, so it is read in the same cycle the valid, stall and flush inputs are applied. An accepted micro-op changes the occupancy outputs at the next edge. The earliest it can appear on the dequeue port is the cycle after it was accepted. Dequeue is also combinational, with no downstream ready, so a presented micro-op counts as taken at the coming edge. The bench changes inputs on the falling edge. It reads readies 1 ns later and pushes the accepted items into per-thread expected queues. The monitor samples the output 2 ns after the falling edge and pops from the matching queue. Occupancies are read one full cycle after the last stimulus. Three instances, one per policy, run on the same stimulus so that the limits of each policy can be compared.

// File: rtl/uopq_pkg.sv
package uopq_pkg;

    localparam int PAYLOAD_W = 16;
    localparam int NTHR      = 2;

    typedef enum logic [1:0] {
        SHARE_PART = 2'd0,
        SHARE_CAP  = 2'd1,
        SHARE_FULL = 2'd2
    } share_mode_e;

    typedef struct packed {
        logic                 tid;
        logic [PAYLOAD_W-1:0] data;
    } uop_t;

    // Largest number of entries a single thread may hold under a policy.
    function automatic int thread_limit(share_mode_e m, int depth, int cap);
        case (m)
            SHARE_PART: return depth / 2;
            SHARE_CAP:  return cap;
            default:    return depth;
        endcase
    endfunction

endpackage

// File: rtl/uopq_lane.sv
module uopq_lane
    import uopq_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          pop,
    input  logic          flush,
    input  uop_t          din,
    output uop_t          head,
    output logic          empty,
    output logic [CW-1:0] cnt_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_C   = CW'(DEPTH);

    uop_t          mem [DEPTH];
    logic [AW-1:0] wr_q, rd_q;
    logic [CW-1:0] cnt_q;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == LAST_IDX) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) wr_q <= bump(wr_q);
            if (pop)  rd_q <= bump(rd_q);
            case ({push, pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push && !flush) mem[wr_q] <= din;
    end

    assign head  = mem[rd_q];
    assign empty = (cnt_q == '0);
    assign cnt_o = cnt_q;

    // R10: admission never pushes into a full lane
    p_lane_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
        push |-> cnt_q < FULL_C);
    // R6: the arbiter never drains an empty lane
    p_lane_no_underflow_r6: assert property (@(posedge clk) disable iff (rst)
        pop |-> cnt_q != '0);
    // R8: flush leaves the lane empty
    p_flush_clears_r8: assert property (@(posedge clk) disable iff (rst)
        flush |=> cnt_q == '0);

endmodule

// File: rtl/uopq_admit.sv
module uopq_admit
    import uopq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CAP = 6,
    parameter share_mode_e MODE = SHARE_CAP,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    vld,
    input  logic [1:0]    flush,
    input  logic [CW-1:0] occ0,
    input  logic [CW-1:0] occ1,
    output logic [1:0]    rdy
);
    localparam int LIMIT = thread_limit(MODE, DEPTH, CAP);
    localparam logic [CW-1:0] LIM_C   = CW'(LIMIT);
    localparam logic [CW:0]   DEPTH_C = (CW + 1)'(DEPTH);
    localparam logic [CW:0]   LAST_C  = (CW + 1)'(DEPTH - 1);

    logic [CW:0] total;
    logic [1:0]  own_ok;
    logic        one_left, clash;
    logic        prio_q;      // 0: thread 0 wins the next conflict

    always_comb begin
        total     = {1'b0, occ0} + {1'b0, occ1};
        one_left  = (total == LAST_C);
        own_ok[0] = (occ0 < LIM_C) && (total < DEPTH_C) && !flush[0];
        own_ok[1] = (occ1 < LIM_C) && (total < DEPTH_C) && !flush[1];
        clash     = (&own_ok) && (&vld) && one_left;
        rdy[0]    = own_ok[0] && !(clash && prio_q);
        rdy[1]    = own_ok[1] && !(clash && !prio_q);
    end

    always_ff @(posedge clk) begin
        if (rst)        prio_q <= 1'b0;
        else if (clash) prio_q <= ~prio_q;
    end

    // R3 (also R2, R4 by policy): per-thread occupancy stays within the limit
    p_occ_limit_r3: assert property (@(posedge clk) disable iff (rst)
        (occ0 <= LIM_C) && (occ1 <= LIM_C));
    // R10: both threads together never exceed the depth
    p_total_bound_r10: assert property (@(posedge clk) disable iff (rst)
        total <= DEPTH_C);
    // R9: with a single free slot, at most one thread is admitted
    p_one_slot_r9: assert property (@(posedge clk) disable iff (rst)
        (one_left && (&vld)) |-> !(&rdy));
    // R2: a thread at its limit is held off
    p_at_limit_stop_r2: assert property (@(posedge clk) disable iff (rst)
        (occ0 == LIM_C) |-> !rdy[0]);

endmodule

// File: rtl/uopq_drain_arb.sv
module uopq_drain_arb (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] avail,
    input  logic [1:0] stall,
    input  logic [1:0] flush,
    output logic [1:0] grant
);
    logic [1:0] elig;
    logic       last_q;   // thread served most recently

    always_comb begin
        elig = avail & ~stall & ~flush;
        if (&elig) grant = last_q ? 2'b01 : 2'b10;
        else       grant = elig;
    end

    always_ff @(posedge clk) begin
        if (rst)         last_q <= 1'b1;
        else if (|grant) last_q <= grant[1];
    end

    // R6: at most one thread drains per cycle
    p_one_out_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));
    // R6: stalled threads are skipped
    p_skip_stalled_r6: assert property (@(posedge clk) disable iff (rst)
        (grant & stall) == 2'b00);
    // R7: alternation under contention
    p_rr_to_t1_r7: assert property (@(posedge clk) disable iff (rst)
        ((&elig) && $past(grant) == 2'b01) |-> grant == 2'b10);
    p_rr_to_t0_r7: assert property (@(posedge clk) disable iff (rst)
        ((&elig) && $past(grant) == 2'b10) |-> grant == 2'b01);

endmodule

// File: rtl/uopq_dual_thread.sv
module uopq_dual_thread
    import uopq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CAP = 6,
    parameter share_mode_e MODE = SHARE_CAP,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 t0_valid_i,
    input  logic [PAYLOAD_W-1:0] t0_data_i,
    output logic                 t0_ready_o,
    input  logic                 t1_valid_i,
    input  logic [PAYLOAD_W-1:0] t1_data_i,
    output logic                 t1_ready_o,
    input  logic [1:0]           stall_i,
    input  logic [1:0]           flush_i,
    output logic                 out_valid_o,
    output logic                 out_thread_o,
    output logic [PAYLOAD_W-1:0] out_data_o,
    output logic [CW-1:0]        occ0_o,
    output logic [CW-1:0]        occ1_o
);
    logic [1:0]    vld, rdy, push, grant, avail;
    uop_t          din  [NTHR];
    uop_t          head [NTHR];
    logic [1:0]    empty;
    logic [CW-1:0] occ  [NTHR];
    uop_t          sel;

    assign vld  = {t1_valid_i, t0_valid_i};
    assign push = vld & rdy;

    always_comb begin
        din[0] = '{tid: 1'b0, data: t0_data_i};
        din[1] = '{tid: 1'b1, data: t1_data_i};
    end

    for (genvar g = 0; g < NTHR; g++) begin : g_lane
        uopq_lane #(.DEPTH(DEPTH)) u_lane (
            .clk   (clk),
            .rst   (rst),
            .push  (push[g]),
            .pop   (grant[g]),
            .flush (flush_i[g]),
            .din   (din[g]),
            .head  (head[g]),
            .empty (empty[g]),
            .cnt_o (occ[g])
        );
    end

    uopq_admit #(.DEPTH(DEPTH), .CAP(CAP), .MODE(MODE)) u_admit (
        .clk   (clk),
        .rst   (rst),
        .vld   (vld),
        .flush (flush_i),
        .occ0  (occ[0]),
        .occ1  (occ[1]),
        .rdy   (rdy)
    );

    assign avail = ~empty;

    uopq_drain_arb u_arb (
        .clk   (clk),
        .rst   (rst),
        .avail (avail),
        .stall (stall_i),
        .flush (flush_i),
        .grant (grant)
    );

    assign sel          = grant[1] ? head[1] : head[0];
    assign out_valid_o  = |grant;
    assign out_thread_o = sel.tid;
    assign out_data_o   = sel.data;
    assign t0_ready_o   = rdy[0];
    assign t1_ready_o   = rdy[1];
    assign occ0_o       = occ[0];
    assign occ1_o       = occ[1];

    // R1: stored tag agrees with the lane chosen by the arbiter
    p_tag_match_r1: assert property (@(posedge clk) disable iff (rst)
        out_valid_o |-> out_thread_o == grant[1]);
    // R8: flushing thread 0 leaves an idle thread 1 unchanged
    p_flush_keeps_other_r8: assert property (@(posedge clk) disable iff (rst)
        (flush_i == 2'b01 && !push[1] && !grant[1]) |=> occ[1] == $past(occ[1]));

endmodule

// File: tb/sim_uopq_dual_thread.sv
module sim_uopq_dual_thread;
    import uopq_pkg::*;

    localparam int DEPTH = 8;
    localparam int CAP   = 6;
    localparam int CW    = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;   // 250 MHz

    logic                 v0 = 0, v1 = 0;
    logic [PAYLOAD_W-1:0] d0 = '0, d1 = '0;
    logic [1:0]           st = '0, fl = '0;

    // u0: capped policy (scoreboarded); up: split; uf: open
    logic a_r0, a_r1, a_ov, a_ot; logic [PAYLOAD_W-1:0] a_od; logic [CW-1:0] a_o0, a_o1;
    logic p_r0, p_r1, p_ov, p_ot; logic [PAYLOAD_W-1:0] p_od; logic [CW-1:0] p_o0, p_o1;
    logic f_r0, f_r1, f_ov, f_ot; logic [PAYLOAD_W-1:0] f_od; logic [CW-1:0] f_o0, f_o1;

    uopq_dual_thread #(.DEPTH(DEPTH), .CAP(CAP), .MODE(SHARE_CAP)) u0 (
        .clk(clk), .rst(rst),
        .t0_valid_i(v0), .t0_data_i(d0), .t0_ready_o(a_r0),
        .t1_valid_i(v1), .t1_data_i(d1), .t1_ready_o(a_r1),
        .stall_i(st), .flush_i(fl),
        .out_valid_o(a_ov), .out_thread_o(a_ot), .out_data_o(a_od),
        .occ0_o(a_o0), .occ1_o(a_o1));

    uopq_dual_thread #(.DEPTH(DEPTH), .CAP(CAP), .MODE(SHARE_PART)) up (
        .clk(clk), .rst(rst),
        .t0_valid_i(v0), .t0_data_i(d0), .t0_ready_o(p_r0),
        .t1_valid_i(v1), .t1_data_i(d1), .t1_ready_o(p_r1),
        .stall_i(st), .flush_i(fl),
        .out_valid_o(p_ov), .out_thread_o(p_ot), .out_data_o(p_od),
        .occ0_o(p_o0), .occ1_o(p_o1));

    uopq_dual_thread #(.DEPTH(DEPTH), .CAP(CAP), .MODE(SHARE_FULL)) uf (
        .clk(clk), .rst(rst),
        .t0_valid_i(v0), .t0_data_i(d0), .t0_ready_o(f_r0),
        .t1_valid_i(v1), .t1_data_i(d1), .t1_ready_o(f_r1),
        .stall_i(st), .flush_i(fl),
        .out_valid_o(f_ov), .out_thread_o(f_ot), .out_data_o(f_od),
        .occ0_o(f_o0), .occ1_o(f_o1));

    int nchk = 0, nerr = 0;
    bit done = 0;
    logic [PAYLOAD_W-1:0] exp0[$], exp1[$];
    int seq_thr[$];
    int cnt0 = 0, cnt1 = 0;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual %0d expected %0d", req, act, expv);
        end
    endtask

    // Driver: one cycle of stimulus; readies read 1 ns after the falling edge
    task automatic cyc(input bit tv0, input bit tv1, input logic [1:0] tst, input logic [1:0] tfl);
        @(negedge clk);
        v0 = tv0; v1 = tv1; st = tst; fl = tfl;
        d0 = {1'b0, 15'(cnt0)};
        d1 = {1'b1, 15'(cnt1)};
        #1;
        if (tfl[0]) exp0.delete();
        if (tfl[1]) exp1.delete();
        if (v0 && a_r0) begin exp0.push_back(d0); cnt0++; end
        if (v1 && a_r1) begin exp1.push_back(d1); cnt1++; end
    endtask

    task automatic idle(input logic [1:0] tst);
        cyc(1'b0, 1'b0, tst, 2'b00);
    endtask

    // Monitor: compares u0's output against the per-thread expected queues
    always begin
        @(negedge clk);
        #2;
        if (!rst) begin
            chk((32'(a_o0) + 32'(a_o1)) <= DEPTH, "R10 occupancy sum", 32'(a_o0) + 32'(a_o1), DEPTH);
            if (a_ov) begin
                seq_thr.push_back(int'(a_ot));
                chk(!st[a_ot], "R6 stalled thread emitted", 1, 0);
                if (a_ot == 1'b0) begin
                    if (exp0.size() == 0) chk(0, "R1 unexpected t0 item", int'(a_od), -1);
                    else chk(a_od == exp0.pop_front(), "R1 t0 order/payload", int'(a_od), 0);
                end else begin
                    if (exp1.size() == 0) chk(0, "R1 unexpected t1 item", int'(a_od), -1);
                    else chk(a_od == exp1.pop_front(), "R1 t1 order/payload", int'(a_od), 0);
                end
                chk(a_od[PAYLOAD_W-1] == a_ot, "R1 tag", int'(a_ot), int'(a_od[PAYLOAD_W-1]));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++; nerr++;
            $display("FAIL R1 watchdog expired actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(a_o0 == 0 && a_o1 == 0, "R10 reset occupancy", int'(a_o0) + int'(a_o1), 0);
        chk(a_ov == 0, "R10 reset out_valid", int'(a_ov), 0);
        @(negedge clk);
        rst = 1'b0;

        // R2, R3, R4: thread 0 alone fills under each policy
        for (int i = 0; i < 9; i++) cyc(1'b1, 1'b0, 2'b11, 2'b00);
        chk(a_r0 == 0, "R3 ready at cap", int'(a_r0), 0);
        chk(p_r0 == 0, "R2 ready at half", int'(p_r0), 0);
        chk(f_r0 == 0, "R4 ready when full", int'(f_r0), 0);
        // R5: the other thread still gets in; R4: not when full
        cyc(1'b1, 1'b1, 2'b11, 2'b00);
        chk(a_r1 == 1, "R5 capped other thread ready", int'(a_r1), 1);
        chk(p_r1 == 1, "R5 split other thread ready", int'(p_r1), 1);
        chk(f_r1 == 0, "R4 open full blocks other", int'(f_r1), 0);
        idle(2'b11);
        chk(a_o0 == CAP && a_o1 == 1, "R3 capped occupancy", int'(a_o0), CAP);
        chk(p_o0 == DEPTH/2 && p_o1 == 1, "R2 split occupancy", int'(p_o0), DEPTH/2);
        chk(f_o0 == DEPTH && f_o1 == 0, "R4 open occupancy", int'(f_o0), DEPTH);

        // R7: drain, thread 0 first, then alternation
        seq_thr.delete();
        repeat (12) idle(2'b00);
        chk(seq_thr.size() == 7, "R1 drained count", seq_thr.size(), 7);
        if (seq_thr.size() >= 3) begin
            chk(seq_thr[0] == 0, "R7 first grant", seq_thr[0], 0);
            chk(seq_thr[1] == 1, "R7 second grant", seq_thr[1], 1);
            chk(seq_thr[2] == 0, "R7 third grant", seq_thr[2], 0);
        end
        chk(a_o0 == 0 && a_o1 == 0, "R1 empty after drain", int'(a_o0) + int'(a_o1), 0);

        // R6: stalled thread 0 is skipped while thread 1 drains
        cyc(1'b1, 1'b1, 2'b01, 2'b00);
        cyc(1'b1, 1'b1, 2'b01, 2'b00);
        repeat (4) idle(2'b01);
        chk(a_o0 == 2, "R6 stalled thread kept", int'(a_o0), 2);
        chk(a_o1 == 0, "R6 free thread drained", int'(a_o1), 0);
        repeat (4) idle(2'b00);

        // R8: flush thread 0, thread 1 untouched
        for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, 2'b11, 2'b00);
        for (int i = 0; i < 2; i++) cyc(1'b0, 1'b1, 2'b11, 2'b00);
        cyc(1'b1, 1'b0, 2'b11, 2'b01);
        chk(a_r0 == 0, "R8 ready low while flushing", int'(a_r0), 0);
        idle(2'b11);
        chk(a_o0 == 0, "R8 flushed occupancy", int'(a_o0), 0);
        chk(a_o1 == 2, "R8 other occupancy", int'(a_o1), 2);
        repeat (5) idle(2'b00);
        chk(exp1.size() == 0 && a_o1 == 0, "R8 other drained intact", exp1.size(), 0);

        // R9: single free slot, alternating winner
        for (int i = 0; i < 4; i++) cyc(1'b1, 1'b0, 2'b11, 2'b00);
        for (int i = 0; i < 3; i++) cyc(1'b0, 1'b1, 2'b11, 2'b00);
        cyc(1'b1, 1'b1, 2'b11, 2'b00);
        chk(a_r0 == 1 && a_r1 == 0, "R9 first conflict to t0", int'({a_r1, a_r0}), 1);
        idle(2'b10);
        cyc(1'b1, 1'b1, 2'b11, 2'b00);
        chk(a_r0 == 0 && a_r1 == 1, "R9 second conflict to t1", int'({a_r1, a_r0}), 2);
        repeat (12) idle(2'b00);
        chk(exp0.size() == 0 && exp1.size() == 0, "R1 all items delivered",
            exp0.size() + exp1.size(), 0);
        chk(a_o0 == 0 && a_o1 == 0, "R10 final occupancy", int'(a_o0) + int'(a_o1), 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

endmodule